// File: doc/BRIEF.md
# Hex Record Loader

This block sits between a serial character receiver and a memory write port. It reads ASCII text one character per cycle over a valid/ready handshake. It picks out hexadecimal load records of the form colon, length, address, type, data bytes and checksum, and turns every data byte into a single write. The write address is the record address plus a 16-bit relocation offset, and successive bytes of a record go to successive addresses.

Parsing is lenient in the ways a hand-typed or dumped file needs. Spaces may appear anywhere. The length and address fields may be cut short with a comma, and hex digits may be upper or lower case. A bad checksum does not stop the writes. It only raises a one-cycle request for the error character 'X'. A record whose length is zero ends the load. The block then raises a sticky done flag and takes no more characters until reset.

Top module: `hexld_loader`

## Requirements
- R1: Every character received before a colon (ASCII 0x3A) is consumed and discarded, hex digits included, and produces no write and no error request.
- R2: The length field is either two hex digits, or one hex digit ended by a comma (ASCII 0x2C), and its value is the number of data bytes (0 to 255).
- R3: The address field is up to four hex digits, and a comma may end it after at least one digit. Data byte k of a record is written at (address + k) modulo 2^16.
- R4: The value on `base_offset` in the cycle that completes the address field is added modulo 2^16 to every write address of that record. Later changes to `base_offset` do not affect that record.
- R5: The type field is two hex digits and must be 00. Any other value drops the record: none of its data is written and no error is requested.
- R6: A data byte is two hex digits, high digit first, and hex letters are accepted in upper or lower case. `wr_en` is high for exactly one cycle, the cycle after the second digit is accepted, with `wr_addr` and `wr_data` valid in that cycle.
- R7: After the two checksum digits, if the modulo-256 sum of the length byte, both address bytes, the type byte, the data bytes and the checksum byte is not zero, `err_req` pulses for one cycle, the cycle after the last checksum digit is accepted. Writes already made are kept.
- R8: A record with length zero raises `done` the cycle after its type field completes. `done` then stays high, `ch_ready` stays low, and no further writes occur until reset.
- R9: Space characters (ASCII 0x20) are accepted and ignored in every field.
- R10: Inside a record, a character that is not a hex digit, a space or a permitted comma aborts the record. A colon restarts a new record at once, and any other character returns the parser to searching for a colon.
- R11: During and after reset, `wr_en`, `err_req` and `done` are low and `ch_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 1 | Character present on `ch_data` |
| ch_data | input | 8 | ASCII character |
| ch_ready | output | 1 | Block accepts a character this cycle |
| base_offset | input | 16 | Offset added to each record address |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Memory write address |
| wr_data | output | 8 | Memory write data |
| err_req | output | 1 | One-cycle request to emit the checksum error character |
| done | output | 1 | Load finished on a zero-length record |

## Verification
Two events can land on the same clock edge: the address field completing and the offset input changing. The bench changes `base_offset` in the very cycle the last address digit is accepted, and changes it again before the data arrives. It then checks that the write lands at the address plus the value present in the completing cycle. A second pairing is the final data byte and the checksum test. A record with a deliberately wrong checksum must still show both of its writes, and then a single error pulse exactly one cycle after the final checksum digit.

// File: rtl/hexld_pkg.sv
`timescale 1ns/1ps
package hexld_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_LEN, ST_ADDR, ST_TYPE, ST_DATA, ST_SUM, ST_DONE
  } ld_state_e;

  typedef struct packed {
    logic       is_hex;
    logic       is_space;
    logic       is_comma;
    logic       is_colon;
    logic [3:0] nib;
  } char_class_t;
endpackage

// File: rtl/hexld_char_class.sv
`timescale 1ns/1ps
module hexld_char_class
  import hexld_pkg::*;
(
  input  logic [7:0]  ch,
  output char_class_t cls
);
  always_comb begin
    cls = '0;
    cls.is_space = (ch == 8'h20);
    cls.is_comma = (ch == 8'h2C);
    cls.is_colon = (ch == 8'h3A);
    if (ch >= 8'h30 && ch <= 8'h39) begin
      cls.is_hex = 1'b1;
      cls.nib    = ch[3:0];
    end else if ((ch >= 8'h41 && ch <= 8'h46) || (ch >= 8'h61 && ch <= 8'h66)) begin
      cls.is_hex = 1'b1;
      cls.nib    = ch[3:0] + 4'd9;
    end
  end
endmodule

// File: rtl/hexld_field.sv
`timescale 1ns/1ps
module hexld_field #(
  parameter int W  = 16,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [3:0]    nib,
  output logic [W-1:0]  acc,
  output logic [CW-1:0] cnt,
  output logic [W-1:0]  shifted
);
  logic [W-1:0]  acc_d;
  logic [CW-1:0] cnt_d;

  assign shifted = {acc[W-5:0], nib};

  always_comb begin
    acc_d = acc;
    cnt_d = cnt;
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (shift) begin
      acc_d = shifted;
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (clr || shift) begin
      acc <= acc_d;
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/hexld_sum.sv
`timescale 1ns/1ps
module hexld_sum (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       add,
  input  logic [7:0] val,
  output logic [7:0] sum
);
  logic [7:0] sum_d;

  always_comb begin
    sum_d = sum;
    if (clr)      sum_d = '0;
    else if (add) sum_d = sum + val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sum <= '0;
    else if (clr || add) sum <= sum_d;
  end
endmodule

// File: rtl/hexld_loader.sv
`timescale 1ns/1ps
module hexld_loader
  import hexld_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ch_valid,
  input  logic [7:0]    ch_data,
  output logic          ch_ready,
  input  logic [AW-1:0] base_offset,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          err_req,
  output logic          done
);
  localparam int ADDR_DIGITS = AW / 4;
  localparam int ADDR_BYTES  = AW / 8;
  localparam int CW          = $clog2(ADDR_DIGITS + 1);
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_DIGITS - 1);
  localparam logic [CW-1:0] BYTE_LAST = CW'(1);

  ld_state_e     state_q, state_d;
  char_class_t   cls;
  logic          take;
  logic          f_clr, f_shift;
  logic [AW-1:0] f_acc, f_shifted, fval;
  logic [CW-1:0] f_cnt, last_cnt;
  logic          fin_digit, fin_comma, fin;
  logic          s_clr, s_add;
  logic [7:0]    s_val, s_sum, addr_bytes;
  logic [7:0]    len_q, len_d, left_q, left_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          wr_en_d, err_d, done_d;
  logic [AW-1:0] wr_addr_d;
  logic [7:0]    wr_data_d;

  hexld_char_class u_cls (.ch(ch_data), .cls(cls));

  hexld_field #(.W(AW), .CW(CW)) u_field (
    .clk(clk), .rst_n(rst_n), .clr(f_clr), .shift(f_shift), .nib(cls.nib),
    .acc(f_acc), .cnt(f_cnt), .shifted(f_shifted)
  );

  hexld_sum u_sum (
    .clk(clk), .rst_n(rst_n), .clr(s_clr), .add(s_add), .val(s_val), .sum(s_sum)
  );

  assign ch_ready = (state_q != ST_DONE);
  assign take     = ch_valid && ch_ready;
  assign last_cnt = (state_q == ST_ADDR) ? ADDR_LAST : BYTE_LAST;

  assign fin_digit = cls.is_hex && (f_cnt == last_cnt);
  assign fin_comma = cls.is_comma && (f_cnt != '0) &&
                     (state_q == ST_LEN || state_q == ST_ADDR);
  assign fin       = fin_digit || fin_comma;
  assign fval      = fin_digit ? f_shifted : f_acc;

  always_comb begin
    addr_bytes = '0;
    for (int i = 0; i < ADDR_BYTES; i++) addr_bytes = addr_bytes + fval[i*8 +: 8];
  end

  always_comb begin
    state_d   = state_q;
    len_d     = len_q;
    left_d    = left_q;
    ptr_d     = ptr_q;
    f_clr     = 1'b0;
    f_shift   = 1'b0;
    s_clr     = 1'b0;
    s_add     = 1'b0;
    s_val     = fval[7:0];
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr;
    wr_data_d = wr_data;
    err_d     = 1'b0;
    done_d    = done;
    if (take && state_q != ST_DONE) begin
      if (state_q == ST_HUNT) begin
        if (cls.is_colon) begin
          state_d = ST_LEN;
          f_clr   = 1'b1;
          s_clr   = 1'b1;
        end
      end else if (cls.is_space) begin
        state_d = state_q;
      end else if (cls.is_colon) begin
        state_d = ST_LEN;
        f_clr   = 1'b1;
        s_clr   = 1'b1;
      end else if (fin) begin
        f_clr = 1'b1;
        s_add = 1'b1;
        unique case (state_q)
          ST_LEN: begin
            len_d   = fval[7:0];
            state_d = ST_ADDR;
          end
          ST_ADDR: begin
            ptr_d   = fval + base_offset;
            s_val   = addr_bytes;
            state_d = ST_TYPE;
          end
          ST_TYPE: begin
            if (fval[7:0] != 8'h00) begin
              s_add   = 1'b0;
              state_d = ST_HUNT;
            end else if (len_q == 8'h00) begin
              done_d  = 1'b1;
              state_d = ST_DONE;
            end else begin
              left_d  = len_q;
              state_d = ST_DATA;
            end
          end
          ST_DATA: begin
            wr_en_d   = 1'b1;
            wr_addr_d = ptr_q;
            wr_data_d = fval[7:0];
            ptr_d     = ptr_q + 1'b1;
            left_d    = left_q - 1'b1;
            if (left_q == 8'h01) state_d = ST_SUM;
          end
          ST_SUM: begin
            s_add   = 1'b0;
            err_d   = ((s_sum + fval[7:0]) != 8'h00);
            state_d = ST_HUNT;
          end
          default: state_d = ST_HUNT;
        endcase
      end else if (cls.is_hex) begin
        f_shift = 1'b1;
      end else begin
        state_d = ST_HUNT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      len_q   <= '0;
      left_q  <= '0;
      ptr_q   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      err_req <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      left_q  <= left_d;
      ptr_q   <= ptr_d;
      wr_en   <= wr_en_d;
      wr_addr <= wr_addr_d;
      wr_data <= wr_data_d;
      err_req <= err_d;
      done    <= done_d;
    end
  end
endmodule

// File: rtl/hexld_loader_chk.sv
`timescale 1ns/1ps
module hexld_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic ch_ready,
  input logic wr_en,
  input logic err_req,
  input logic done
);
  // R8: done is sticky until reset
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R8: no characters taken once done
  assert_done_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ch_ready);
  // R8: no writes once done
  assert_no_write_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !done);
  // R6: a byte needs two characters, so strobes never run back to back
  assert_write_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R7: error request is a single-cycle pulse
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |=> !err_req);
  // R7: checksum verdict never shares a cycle with a data write
  assert_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_req |-> !wr_en);
endmodule

bind hexld_loader hexld_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_ready(ch_ready),
  .wr_en(wr_en), .err_req(err_req), .done(done)
);

// File: tb/hexld_loader_tb.sv
`timescale 1ns/1ps
module hexld_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ch_valid;
  logic [7:0]  ch_data;
  logic        ch_ready;
  logic [15:0] base_offset;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        err_req;
  logic        done;

  int n_chk = 0;
  int n_bad = 0;
  int log_n = 0;
  int err_n = 0;
  logic [15:0] log_a [16];
  logic [7:0]  log_d [16];
  bit finished = 0;

  // expected writes {addr, data}
  localparam logic [23:0] EXP_WR [8] = '{
    24'h1100_11, 24'h1101_22, 24'h1102_33,  // R1 R9 spaced record
    24'h102E_AB, 24'h102F_CD,               // R2 R3 comma fields, lower case
    24'hFFFF_01, 24'h0000_02,               // R4 wrap of offset sum
    24'h1060_55                             // R10 restart on colon
  };

  always #2.5 clk = ~clk;

  hexld_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_ready(ch_ready), .base_offset(base_offset), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .err_req(err_req), .done(done)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (wr_en) begin
        if (log_n < 16) begin
          log_a[log_n] = wr_addr;
          log_d[log_n] = wr_data;
        end
        log_n++;
      end
      if (err_req) err_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] c);
    @(negedge clk);
    ch_valid = 1'b1;
    ch_data  = c;
    @(negedge clk);
    ch_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n       = 1'b0;
    ch_valid    = 1'b0;
    ch_data     = 8'h00;
    base_offset = 16'h1000;
    idle(3);
    chk("R11 wr_en", {31'd0, wr_en}, 32'd0);
    rst_n = 1'b1;
    idle(1);
    chk("R11 ready", {31'd0, ch_ready}, 32'd1);
    chk("R11 done",  {31'd0, done},     32'd0);
    chk("R11 err",   {31'd0, err_req},  32'd0);

    // R1 R9: junk including hex digits, spaces inside fields
    send_str("12xy:03 0100 00 11 22 33 96");
    idle(2);
    chk("R1 R9 writes", log_n, 3);
    chk("R7 good sum no err", err_n, 0);

    // R2 R3 R6 R7: comma-shortened fields, lower case, bad checksum
    send_str(":2,2e,00abcd0");
    send_char("0");
    chk("R7 err pulse timing", {31'd0, err_req}, 32'd1);
    idle(2);
    chk("R7 writes kept", log_n, 5);
    chk("R7 one err", err_n, 1);

    // R4: address plus offset wraps
    send_str(":02EFFF000102 0D");
    idle(2);
    chk("R4 wrap writes", log_n, 7);

    // R10: bad character in address, R5: nonzero type dropped
    send_str(":01005G");
    send_str(":01004001 7F C0");
    idle(2);
    chk("R5 R10 dropped", log_n, 7);
    chk("R5 R10 no err", err_n, 1);

    // R10: colon inside length restarts
    send_str(":0:01006000554A");
    idle(2);
    chk("R10 restart write", log_n, 8);
    chk("R10 restart no err", err_n, 1);

    for (int i = 0; i < 8; i++) begin
      chk("R3/R4/R6 write addr", {16'd0, log_a[i]}, {16'd0, EXP_WR[i][23:8]});
      chk("R3/R4/R6 write data", {24'd0, log_d[i]}, {24'd0, EXP_WR[i][7:0]});
    end

    // R4: offset changes in the cycle the address completes, then again
    send_str(":0100");
    send_char("7");
    @(negedge clk);
    ch_valid    = 1'b1;
    ch_data     = "0";
    base_offset = 16'h2000;
    @(negedge clk);
    ch_valid    = 1'b0;
    base_offset = 16'h3000;
    send_str("009");
    send_char("9");
    chk("R6 strobe timing", {31'd0, wr_en}, 32'd1);
    send_str("F6");
    idle(2);
    chk("R4 sampled offset addr", {16'd0, log_a[8]}, 32'h2070);
    chk("R4 sampled offset data", {24'd0, log_d[8]}, 32'h99);
    chk("R7 no err", err_n, 1);

    // R8: zero-length record ends the load
    send_str(":0,0,00");
    chk("R8 done", {31'd0, done}, 32'd1);
    chk("R8 ready low", {31'd0, ch_ready}, 32'd0);
    @(negedge clk);
    ch_valid = 1'b1;
    ch_data  = "1";
    idle(6);
    ch_valid = 1'b0;
    idle(1);
    chk("R8 no writes after done", log_n, 9);
    chk("R8 done held", {31'd0, done}, 32'd1);

    finish_run();
  end
endmodule